// File: doc/BRIEF.md
# Trace Jump Inferability Classifier

This block sits beside an instruction-trace encoder and looks at every retired instruction, 32-bit or 16-bit compressed, that arrives with a valid strobe. For each instruction it reports whether it is a jump. For a jump it also reports one of two outcomes. The target may be inferable, which means a trace decoder can rebuild it from the program image alone. Otherwise it is uninferable, and the encoder must send it explicitly. The encoder uses these flags to decide which jumps need an address in the trace.

The classification follows a strict rule. A target counts as inferable only in two cases. The first is when it comes from an immediate inside the jump opcode. The second is a register jump whose base register was just written by an upper-immediate instruction retired immediately before it. To recognise that pairing, the block keeps a small record of the previous valid instruction. A JALR whose base register is x0 has a target that can be read from the opcode, so it could be treated either way. An elaboration parameter picks which reading applies. The matching decoder must be built with the same choice, or trace reconstruction breaks.

Top module: `trace_jump_classifier`

## Requirements
- R1: An input word whose bits [1:0] are not 2'b11 is a compressed instruction. Only bits [15:0] are decoded, and bits [31:16] have no effect on the result.
- R2: JAL (bits [6:0] = 7'b1101111) is reported as a jump and as inferable.
- R3: The compressed C.J (bits [1:0]=01, bits [15:13]=101) and C.JAL (bits [1:0]=01, bits [15:13]=001) are reported as jumps and as inferable.
- R4: JALR (bits [6:0]=7'b1100111, bits [14:12]=000) is inferable when the previous valid instruction wrote an upper immediate to a register equal to the JALR base register (bits [19:15]). Otherwise it is uninferable. The qualifying predecessors are LUI (bits [6:0]=7'b0110111, rd = bits [11:7]), AUIPC (bits [6:0]=7'b0010111, rd = bits [11:7]) and C.LUI (bits [1:0]=01, bits [15:13]=011, rd = bits [11:7] other than 0 and 2).
- R5: With TREAT_X0_JALR_INFERABLE = 0, a JALR with base register x0 and no qualifying predecessor is uninferable. With the parameter set to 1, such a JALR is always inferable.
- R6: C.JR and C.JALR are always uninferable jumps. Both have bits [1:0]=10, bits [6:2]=0 and bits [11:7] nonzero. C.JR has bits [15:12]=1000 and C.JALR has bits [15:12]=1001.
- R7: Every other instruction, including C.MV, C.ADD, C.EBREAK and C.ADDI16SP, drives is_jump, inferable and uninferable low.
- R8: Only valid cycles update the previous-instruction record. Idle cycles between an upper-immediate instruction and a JALR keep the pairing. Any valid instruction in between breaks it.
- R9: Reset clears the previous-instruction record, so the first instruction after reset has no qualifying predecessor. Reset also drives all outputs low.
- R10: The outputs are registered. out_valid equals in_valid delayed by one clock, and all flags are low whenever out_valid is low.
- R11: inferable and uninferable are never high together, and is_jump equals their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A retired instruction is present this cycle |
| in_instr | input | INSTR_W | Retired instruction word; compressed ones use the low half |
| out_valid | output | 1 | Classification of the previous cycle's instruction is present |
| is_jump | output | 1 | The classified instruction is a jump |
| inferable | output | 1 | The jump target can be rebuilt by a decoder |
| uninferable | output | 1 | The jump target must be reported |

## Verification
The bench builds two instances side by side from one stimulus stream. One uses TREAT_X0_JALR_INFERABLE = 0 and the other uses 1. Any x0-based JALR therefore shows both readings of R5 in the same cycle, and the two instances must agree on every other instruction. The random mix draws register fields from a small pool, so upper-immediate and JALR pairs often match and often miss. Directed sequences cover idle gaps, broken pairs and a reset between the two halves of a pair.

// File: rtl/trace_jump_pkg.sv
package trace_jump_pkg;

    localparam int REG_IDX_W = 5;

    localparam logic [6:0] OPC_JAL   = 7'b1101111;
    localparam logic [6:0] OPC_JALR  = 7'b1100111;
    localparam logic [6:0] OPC_LUI   = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;

    // per-instruction decode summary
    typedef struct packed {
        logic                 jump;       // any jump form
        logic                 direct;     // target held in opcode immediate
        logic                 reg_jump;   // 32-bit register jump (sequence candidate)
        logic [REG_IDX_W-1:0] base_reg;   // base register of a 32-bit register jump
        logic                 writes_upper;
        logic [REG_IDX_W-1:0] upper_rd;
    } dec_t;

    // record of the previous valid instruction
    typedef struct packed {
        logic                 upper;
        logic [REG_IDX_W-1:0] rd;
    } hist_t;

    // registered classification
    typedef struct packed {
        logic valid;
        logic jump;
        logic inf;
        logic uninf;
    } res_t;

endpackage

// File: rtl/tjc_decode.sv
module tjc_decode
    import trace_jump_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    localparam int HALF_W = INSTR_W / 2;

    logic [HALF_W-1:0] half;
    logic              compressed;

    assign half       = instr[HALF_W-1:0];
    assign compressed = (instr[1:0] != 2'b11);

    always_comb begin
        dec = '0;
        if (compressed) begin
            unique case (half[1:0])
                2'b01: begin
                    // C.J and C.JAL: offset in the opcode
                    if (half[15:13] == 3'b101 || half[15:13] == 3'b001) begin
                        dec.jump   = 1'b1;
                        dec.direct = 1'b1;
                    end
                    // C.LUI; rd 0 and rd 2 are other encodings
                    if (half[15:13] == 3'b011 && half[11:7] != 5'd0 && half[11:7] != 5'd2) begin
                        dec.writes_upper = 1'b1;
                        dec.upper_rd     = half[11:7];
                    end
                end
                2'b10: begin
                    // C.JR / C.JALR: register-held target
                    if ((half[15:12] == 4'b1000 || half[15:12] == 4'b1001) &&
                        half[11:7] != 5'd0 && half[6:2] == 5'd0) begin
                        dec.jump = 1'b1;
                    end
                end
                default: ;
            endcase
        end else begin
            unique case (instr[6:0])
                OPC_JAL: begin
                    dec.jump   = 1'b1;
                    dec.direct = 1'b1;
                end
                OPC_JALR: begin
                    if (instr[14:12] == 3'b000) begin
                        dec.jump     = 1'b1;
                        dec.reg_jump = 1'b1;
                        dec.base_reg = instr[19:15];
                    end
                end
                OPC_LUI, OPC_AUIPC: begin
                    dec.writes_upper = 1'b1;
                    dec.upper_rd     = instr[11:7];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tjc_history.sv
module tjc_history
    import trace_jump_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd,
    input  dec_t  dec,
    output hist_t hist_q
);
    hist_t hist_d;

    always_comb begin
        hist_d = hist_q;
        if (upd) begin
            hist_d.upper = dec.writes_upper;
            hist_d.rd    = dec.upper_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

endmodule

// File: rtl/trace_jump_classifier.sv
module trace_jump_classifier
    import trace_jump_pkg::*;
#(
    parameter int INSTR_W                 = 32,
    parameter bit TREAT_X0_JALR_INFERABLE = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               out_valid,
    output logic               is_jump,
    output logic               inferable,
    output logic               uninferable
);
    dec_t  dec;
    hist_t hist_q;
    res_t  res_d, res_q;
    logic  seq_ok;
    logic  x0_ok;
    logic  target_known;

    tjc_decode #(.INSTR_W(INSTR_W)) i_decode (
        .instr (in_instr),
        .dec   (dec)
    );

    tjc_history i_history (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (in_valid),
        .dec    (dec),
        .hist_q (hist_q)
    );

    // register jump paired with the upper-immediate write just before it
    assign seq_ok = hist_q.upper && (hist_q.rd == dec.base_reg);

    generate
        if (TREAT_X0_JALR_INFERABLE) begin : g_x0_known
            assign x0_ok = (dec.base_reg == '0);
        end else begin : g_x0_strict
            assign x0_ok = 1'b0;
        end
    endgenerate

    assign target_known = dec.direct || (dec.reg_jump && (seq_ok || x0_ok));

    always_comb begin
        res_d       = '0;
        res_d.valid = in_valid;
        if (in_valid && dec.jump) begin
            res_d.jump  = 1'b1;
            res_d.inf   = target_known;
            res_d.uninf = !target_known;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid   = res_q.valid;
    assign is_jump     = res_q.jump;
    assign inferable   = res_q.inf;
    assign uninferable = res_q.uninf;

endmodule

// File: rtl/tjc_checker.sv
module tjc_checker #(
    parameter int INSTR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [INSTR_W-1:0] in_instr,
    input logic               out_valid,
    input logic               is_jump,
    input logic               inferable,
    input logic               uninferable
);
    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(inferable && uninferable));

    p_jump_split_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (is_jump == (inferable || uninferable)));

    p_valid_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !is_jump && !inferable && !uninferable));

    p_jal_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[1:0] == 2'b11 && in_instr[6:0] == 7'b1101111) |=> inferable);

    p_cjr_unknown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[1:0] == 2'b10 && in_instr[15:13] == 3'b100 &&
         in_instr[6:2] == 5'd0 && in_instr[11:7] != 5'd0) |=> uninferable);

    p_cj_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[1:0] == 2'b01 && in_instr[15:13] == 3'b101) |=> inferable);

endmodule

bind trace_jump_classifier tjc_checker #(.INSTR_W(INSTR_W)) i_tjc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_instr    (in_instr),
    .out_valid   (out_valid),
    .is_jump     (is_jump),
    .inferable   (inferable),
    .uninferable (uninferable)
);

// File: tb/test_trace_jump_classifier.sv
module test_trace_jump_classifier;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic        ov0, j0, i0, u0;
    logic        ov1, j1, i1, u1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model history
    bit       m_up = 1'b0;
    bit [4:0] m_rd = '0;

    always #4 clk = ~clk;  // 125 MHz

    trace_jump_classifier #(.TREAT_X0_JALR_INFERABLE(1'b0)) i_trace_jump_classifier (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .out_valid(ov0), .is_jump(j0), .inferable(i0), .uninferable(u0));

    trace_jump_classifier #(.TREAT_X0_JALR_INFERABLE(1'b1)) i_trace_jump_classifier_x0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .out_valid(ov1), .is_jump(j1), .inferable(i1), .uninferable(u1));

    // ---------------- encoders ----------------
    function automatic logic [31:0] e_jal(logic [4:0] rd);
        return {$urandom()%20'hFFFFF, rd, 7'b1101111};
    endfunction
    function automatic logic [31:0] e_jalr(logic [4:0] rd, logic [4:0] rs1);
        return {12'($urandom()), rs1, 3'b000, rd, 7'b1100111};
    endfunction
    function automatic logic [31:0] e_lui(logic [4:0] rd);
        return {20'($urandom()), rd, 7'b0110111};
    endfunction
    function automatic logic [31:0] e_auipc(logic [4:0] rd);
        return {20'($urandom()), rd, 7'b0010111};
    endfunction
    function automatic logic [31:0] e_addi(logic [4:0] rd, logic [4:0] rs1);
        return {12'($urandom()), rs1, 3'b000, rd, 7'b0010011};
    endfunction
    function automatic logic [31:0] e_clui(logic [4:0] rd);
        return {16'($urandom()), 3'b011, 1'b0, rd, 5'b00001, 2'b01};
    endfunction
    function automatic logic [31:0] e_cj(bit link);
        return {16'($urandom()), (link ? 3'b001 : 3'b101), 11'($urandom()), 2'b01};
    endfunction
    function automatic logic [31:0] e_cjr(bit link, logic [4:0] rs1);
        return {16'($urandom()), 3'b100, link, rs1, 5'b00000, 2'b10};
    endfunction
    function automatic logic [31:0] e_cmv(logic [4:0] rd, logic [4:0] rs2);
        return {16'($urandom()), 4'b1000, rd, rs2, 2'b10};
    endfunction

    // ---------------- reference model ----------------
    // returns {jump, inf, uninf}
    function automatic logic [2:0] classify(logic [31:0] w, bit pu, bit [4:0] prd, bit x0);
        logic [15:0] h;
        bit jmp, inf;
        h = w[15:0];
        jmp = 0; inf = 0;
        if (w[1:0] == 2'b01) begin
            if (h[15:13] == 3'b101 || h[15:13] == 3'b001) begin jmp = 1; inf = 1; end
        end else if (w[1:0] == 2'b10) begin
            if (h[15:13] == 3'b100 && h[11:7] != 0 && h[6:2] == 0) jmp = 1;
        end else if (w[1:0] == 2'b11) begin
            if (w[6:0] == 7'b1101111) begin jmp = 1; inf = 1; end
            else if (w[6:0] == 7'b1100111 && w[14:12] == 3'b000) begin
                jmp = 1;
                inf = (pu && prd == w[19:15]) || (x0 && w[19:15] == 0);
            end
        end
        return {jmp, jmp && inf, jmp && !inf};
    endfunction

    function automatic logic [5:0] upper_of(logic [31:0] w);
        if (w[1:0] == 2'b11 && (w[6:0] == 7'b0110111 || w[6:0] == 7'b0010111))
            return {1'b1, w[11:7]};
        if (w[1:0] == 2'b01 && w[15:13] == 3'b011 && w[11:7] != 0 && w[11:7] != 2)
            return {1'b1, w[11:7]};
        return 6'b0;
    endfunction

    task automatic chk(string req, string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // drive one cycle and check both instances one edge later
    task automatic step(bit v, logic [31:0] w, string req);
        logic [2:0] e0, e1;
        logic [5:0] up;
        e0 = v ? classify(w, m_up, m_rd, 1'b0) : 3'b0;
        e1 = v ? classify(w, m_up, m_rd, 1'b1) : 3'b0;
        in_valid = v;
        in_instr = w;
        @(posedge clk);
        #1;
        chk(req, "strict", {ov0, j0, i0, u0}, {v, e0});
        chk(req, "x0",     {ov1, j1, i1, u1}, {v, e1});
        if (v) begin
            up = upper_of(w);
            m_up = up[5];
            m_rd = up[4:0];
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R9", "reset outputs", {ov0, j0, i0, u0}, 4'b0);
        chk("R9", "reset outputs x0", {ov1, j1, i1, u1}, 4'b0);
        m_up = 0;
        m_rd = 0;
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] rnd_instr();
        logic [4:0] r, s;
        r = 5'($urandom() % 4);
        s = 5'($urandom() % 4);
        case ($urandom() % 12)
            0:  return e_jal(r);
            1, 2: return e_jalr(r, s);
            3:  return e_lui(r);
            4:  return e_auipc(r);
            5:  return e_clui(($urandom() % 2) ? 5'd1 : 5'd3);
            6:  return e_cj($urandom() % 2);
            7:  return e_cjr($urandom() % 2, (s == 0) ? 5'd1 : s);
            8:  return e_addi(r, s);
            9:  return e_cmv(r | 5'd1, s | 5'd1);
            10: return e_clui(5'd2);  // C.ADDI16SP
            default: return $urandom();
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();

        // R2 / R3 direct targets
        step(1, e_jal(5'd1), "R2");
        step(1, e_cj(1'b0), "R3");
        step(1, e_cj(1'b1), "R3");
        // R1: upper half ignored for compressed
        step(1, {16'hFFFF, 3'b101, 11'h155, 2'b01}, "R1");
        step(1, {16'h0000, 3'b101, 11'h155, 2'b01}, "R1");
        step(1, {16'h1267, 16'h0001}, "R1");  // C.NOP with JALR-looking upper half
        // R4 pairing
        step(1, e_lui(5'd5), "R4");
        step(1, e_jalr(5'd1, 5'd5), "R4");
        step(1, e_auipc(5'd6), "R4");
        step(1, e_jalr(5'd0, 5'd7), "R4");
        step(1, e_clui(5'd3), "R4");
        step(1, e_jalr(5'd1, 5'd3), "R4");
        step(1, e_clui(5'd2), "R7");
        step(1, e_jalr(5'd1, 5'd2), "R4");
        // R5 x0 base without predecessor
        step(1, e_addi(5'd1, 5'd1), "R7");
        step(1, e_jalr(5'd1, 5'd0), "R5");
        // R6
        step(1, e_cjr(1'b0, 5'd1), "R6");
        step(1, e_lui(5'd1), "R6");
        step(1, e_cjr(1'b1, 5'd1), "R6");
        step(1, e_cmv(5'd1, 5'd2), "R7");
        // R8 idle gap keeps pair, valid instruction breaks it
        step(1, e_lui(5'd9), "R8");
        step(0, e_jalr(5'd1, 5'd9), "R10");
        step(0, '0, "R10");
        step(1, e_jalr(5'd1, 5'd9), "R8");
        step(1, e_auipc(5'd9), "R8");
        step(1, e_addi(5'd2, 5'd2), "R8");
        step(1, e_jalr(5'd1, 5'd9), "R8");
        // R9 reset between halves of a pair
        step(1, e_lui(5'd4), "R9");
        do_reset();
        step(1, e_jalr(5'd1, 5'd4), "R9");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            step(($urandom() % 5) != 0, rnd_instr(), "R11");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule